// File: doc/BRIEF.md
# Dual-Channel Threshold Alarm Engine

This block watches a stream of 14-bit two's complement sensor samples, each marked by a valid strobe. It raises an event on either of two independent alarm channels. Each channel has its own threshold, comparison direction and averaging window. A channel tests in one of two ways:

- **Static mode:** the sample itself is tested against the threshold.
- **Dynamic mode:** the block forms the difference between each sample and the one before it. It adds up those differences over a window of N deltas and compares the sum against the threshold multiplied by N. This gives an average rate-of-change test without a divider.

Software programs the block through a small register port. A read of the status address returns the latched flags and clears them. Each channel has a sticky flag. A combined alarm pin is the OR of the two flags, gated by a control bit.

Top module: `dual_alarm_engine`

## Requirements
- R1: While reset is high and on the cycle after it falls, both alarm flags and the alarm pin are 0. Every register at addresses 0 to 5 reads as 0x0000 after reset.
- R2: The register map is as follows:
  - Address 0 holds the threshold word of channel 0 and address 1 holds that of channel 1. Bit 15 is the polarity and bits 13:0 are the threshold. Bit 14 reads 0.
  - Addresses 2 and 3 hold the window counts of channels 0 and 1 in bits 7:0. The other bits read 0.
  - Address 4 is control in bits 4:0. The other bits read 0.
  - Address 5 is status, with the channel 0 flag in bit 0 and the channel 1 flag in bit 1.
  - Read data appears on the cycle after the read strobe.
  - A write takes effect for samples from the next cycle on.
- R3: In static mode, a valid sample sets the channel flag in the following cycle when it meets the test for its polarity. With polarity 1 the sample must be strictly greater than the signed threshold. With polarity 0 it must be strictly less.
- R4: In dynamic mode, the first valid sample after enable, mode entry or reset only seeds the previous-sample register. Each later valid sample adds (sample − previous) to a signed sum. When the number of deltas reaches or exceeds N, the sum is compared strictly against threshold × N, using the polarity rule of R3. The window then restarts empty.
- R5: A window count of 0 behaves as a count of 1.
- R6: Control bit 0 enables channel 0 and bit 1 enables channel 1. Bit 2 selects dynamic mode for channel 0 and bit 3 selects it for channel 1. The two channels never influence each other.
- R7: A disabled channel never sets its flag. Disabling a channel, or switching it to static mode, discards its dynamic history.
- R8: A flag stays set until a read of the status address. That read returns the flags as they were before the read, and the flags are 0 on the following cycle.
- R9: If an event occurs on the same cycle as a status read, the flag remains set.
- R10: The alarm pin equals control bit 4 AND the OR of both flags. It changes on the same cycle as the flags.
- R11: A sample presented without the valid strobe has no effect on flags or on dynamic history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Signed sample |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| alm_flag | output | 2 | Sticky per-channel alarm flags |
| alm_pin | output | 1 | Combined gated alarm output |

## Verification
A status read that clears the flags can land on the same edge as a valid sample that raises a new event. The two then compete for the same flag bit.

The bench provokes this directly: it holds a flag set and issues the status read together with a sample that exceeds the threshold. It expects the read to return the old flags and the flag to stay set afterwards. It also issues the read alone and expects the flag to drop.

Random phases overlap status reads, reconfiguration writes and samples in the same cycle. Each cycle's flags, pin and read data are compared against a bench reference model.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int REG_W  = 16;
  localparam int SMP_W  = 14;
  localparam int CNT_W  = 8;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;
  localparam int ACC_W  = SMP_W + CNT_W + 2;
  localparam int CTRL_W = 2 * NCH + 1;
  localparam int A_CTRL = 2 * NCH;
  localparam int A_STAT = 2 * NCH + 1;
  localparam int PIN_BIT = 2 * NCH;
endpackage

// File: rtl/alarm_channel.sv
module alarm_channel #(
  parameter int DW = 14,
  parameter int CW = 8,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          dyn,
  input  logic          pol,
  input  logic [DW-1:0] thr,
  input  logic [CW-1:0] n_raw,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic          evt
);
  logic                 seeded_q;
  logic [DW-1:0]        prev_q;
  logic signed [AW-1:0] acc_q;
  logic [CW:0]          cnt_q;

  logic signed [AW-1:0] smp_ext, prev_ext, thr_ext, n_ext, delta, acc_new, limit;
  logic [CW-1:0]        n_eff;
  logic [CW:0]          cnt_new;
  logic                 win_end, hit_dyn, hit_st;

  always_comb begin
    smp_ext  = {{(AW-DW){smp_data[DW-1]}}, smp_data};
    prev_ext = {{(AW-DW){prev_q[DW-1]}}, prev_q};
    thr_ext  = {{(AW-DW){thr[DW-1]}}, thr};
    n_eff    = (n_raw == '0) ? CW'(1) : n_raw;
    n_ext    = {{(AW-CW){1'b0}}, n_eff};
    delta    = smp_ext - prev_ext;
    acc_new  = acc_q + delta;
    limit    = thr_ext * n_ext;
    cnt_new  = cnt_q + 1'b1;
    win_end  = cnt_new >= {1'b0, n_eff};
    hit_dyn  = pol ? (acc_new > limit) : (acc_new < limit);
    hit_st   = pol ? (smp_ext > thr_ext) : (smp_ext < thr_ext);
    evt      = smp_valid && en && (dyn ? (seeded_q && win_end && hit_dyn) : hit_st);
  end

  always_ff @(posedge clk) begin
    if (rst || !en || !dyn) begin
      seeded_q <= 1'b0;
      prev_q   <= '0;
      acc_q    <= '0;
      cnt_q    <= '0;
    end else if (smp_valid) begin
      seeded_q <= 1'b1;
      prev_q   <= smp_data;
      if (seeded_q) begin
        if (win_end) begin
          acc_q <= '0;
          cnt_q <= '0;
        end else begin
          acc_q <= acc_new;
          cnt_q <= cnt_new;
        end
      end
    end
  end
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
  import alm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic                       re,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [REG_W-1:0]           wdata,
  input  logic [NCH-1:0]             flags,
  output logic [REG_W-1:0]           rdata,
  output logic                       stat_clr,
  output logic [NCH-1:0]             pol,
  output logic [NCH-1:0][SMP_W-1:0]  thr,
  output logic [NCH-1:0][CNT_W-1:0]  cnt,
  output logic [CTRL_W-1:0]          ctrl
);
  logic [REG_W-1:0] rd_mux;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[REG_W-2:SMP_W]};
  assign stat_clr     = re && (addr == ADDR_W'(A_STAT));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        pol[ch] <= 1'b0;
        thr[ch] <= '0;
        cnt[ch] <= '0;
      end else if (we) begin
        if (addr == ADDR_W'(ch)) begin
          pol[ch] <= wdata[REG_W-1];
          thr[ch] <= wdata[SMP_W-1:0];
        end
        if (addr == ADDR_W'(NCH + ch))
          cnt[ch] <= wdata[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctrl <= '0;
    else if (we && addr == ADDR_W'(A_CTRL))
      ctrl <= wdata[CTRL_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(i))
        rd_mux = {pol[i], {(REG_W-1-SMP_W){1'b0}}, thr[i]};
      if (addr == ADDR_W'(NCH + i))
        rd_mux = REG_W'(cnt[i]);
    end
    if (addr == ADDR_W'(A_CTRL)) rd_mux = REG_W'(ctrl);
    if (addr == ADDR_W'(A_STAT)) rd_mux = REG_W'(flags);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (re)
      rdata <= rd_mux;
  end
endmodule

// File: rtl/dual_alarm_engine.sv
module dual_alarm_engine
  import alm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NCH-1:0]    alm_flag,
  output logic              alm_pin
);
  logic                      stat_clr;
  logic [NCH-1:0]            pol_w, evt_w, flag_nxt;
  logic [NCH-1:0][SMP_W-1:0] thr_w;
  logic [NCH-1:0][CNT_W-1:0] cnt_w;
  logic [CTRL_W-1:0]         ctrl_w;

  alarm_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .re(reg_re), .addr(reg_addr),
    .wdata(reg_wdata), .flags(alm_flag), .rdata(reg_rdata),
    .stat_clr(stat_clr), .pol(pol_w), .thr(thr_w), .cnt(cnt_w), .ctrl(ctrl_w)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    alarm_channel #(.DW(SMP_W), .CW(CNT_W), .AW(ACC_W)) u_chan (
      .clk(clk), .rst(rst),
      .en(ctrl_w[ch]), .dyn(ctrl_w[NCH + ch]),
      .pol(pol_w[ch]), .thr(thr_w[ch]), .n_raw(cnt_w[ch]),
      .smp_valid(smp_valid), .smp_data(smp_data), .evt(evt_w[ch])
    );
  end

  assign flag_nxt = (alm_flag & ~{NCH{stat_clr}}) | evt_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_flag <= '0;
      alm_pin  <= 1'b0;
    end else begin
      alm_flag <= flag_nxt;
      alm_pin  <= ctrl_w[PIN_BIT] & (|flag_nxt);
    end
  end
endmodule

// File: rtl/alarm_engine_chk.sv
module alarm_engine_chk
  import alm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic              reg_re,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [CTRL_W-1:0] ctrl,
  input logic [NCH-1:0]    alm_flag,
  input logic              alm_pin
);
  logic stat_rd;
  assign stat_rd = reg_re && (reg_addr == ADDR_W'(A_STAT));

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (alm_flag == '0 && !alm_pin)); // R1

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !smp_valid) |=> (alm_flag == '0)); // R8

  AST_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ((alm_flag & ~$past(alm_flag)) == '0)); // R11

  AST_PIN_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
    alm_pin |-> (|alm_flag)); // R10

  AST_PIN_GATED: assert property (@(posedge clk) disable iff (rst)
    !ctrl[PIN_BIT] |=> !alm_pin); // R10

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
      (alm_flag[ch] && !stat_rd) |=> alm_flag[ch]); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
      (!ctrl[ch] && !alm_flag[ch]) |=> !alm_flag[ch]); // R7
  end
endmodule

bind dual_alarm_engine alarm_engine_chk u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .reg_re(reg_re),
  .reg_addr(reg_addr), .ctrl(ctrl_w), .alm_flag(alm_flag), .alm_pin(alm_pin)
);

// File: tb/dual_alarm_engine_tb.sv
`timescale 1ns/1ps
module dual_alarm_engine_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [13:0] smp_data = '0;
  logic        reg_we = 1'b0;
  logic        reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  alm_flag;
  logic        alm_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  bit        m_pol [2];
  int        m_thr [2];
  int        m_cnt [2];
  int        m_ctrl;
  bit  [1:0] m_flag;
  bit        m_pin;
  bit        m_hp  [2];
  int        m_prev[2];
  int        m_acc [2];
  int        m_n   [2];

  always #4 clk = ~clk;

  dual_alarm_engine u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .alm_flag(alm_flag), .alm_pin(alm_pin)
  );

  function automatic int sx14(input logic [13:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [15:0] model_read(input int a);
    if (a == 0 || a == 1) return {m_pol[a], 1'b0, 14'(m_thr[a])};
    if (a == 2 || a == 3) return 16'(m_cnt[a-2]);
    if (a == 4) return 16'(m_ctrl);
    if (a == 5) return {14'd0, m_flag};
    return 16'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_pol[c] = 0; m_thr[c] = 0; m_cnt[c] = 0;
      m_hp[c] = 0; m_prev[c] = 0; m_acc[c] = 0; m_n[c] = 0;
    end
    m_ctrl = 0; m_flag = '0; m_pin = 0;
  endtask

  // one cycle: drive at negedge, advance model at posedge, check at next negedge
  task automatic step(input bit v, input logic [13:0] d, input bit we, input bit re,
                      input logic [2:0] a, input logic [15:0] wd, input string tag);
    logic [15:0] exp_rd;
    bit   [1:0]  evt;
    smp_valid = v; smp_data = d; reg_we = we; reg_re = re; reg_addr = a; reg_wdata = wd;
    @(posedge clk);
    exp_rd = model_read(int'(a));
    evt = '0;
    for (int c = 0; c < 2; c++) begin
      bit en, dy;
      int s, nn;
      en = m_ctrl[c];
      dy = m_ctrl[2+c];
      s  = sx14(d);
      if (!en || !dy) begin
        m_hp[c] = 0; m_prev[c] = 0; m_acc[c] = 0; m_n[c] = 0;
      end
      if (en && v) begin
        if (!dy) begin
          evt[c] = m_pol[c] ? (s > m_thr[c]) : (s < m_thr[c]);
        end else if (!m_hp[c]) begin
          m_hp[c] = 1; m_prev[c] = s;
        end else begin
          m_acc[c] += s - m_prev[c];
          m_n[c]++;
          m_prev[c] = s;
          nn = (m_cnt[c] == 0) ? 1 : m_cnt[c];
          if (m_n[c] >= nn) begin
            evt[c] = m_pol[c] ? (m_acc[c] > m_thr[c]*nn) : (m_acc[c] < m_thr[c]*nn);
            m_acc[c] = 0; m_n[c] = 0;
          end
        end
      end
    end
    if (re && a == 3'd5) m_flag = '0;
    m_flag = m_flag | evt;
    m_pin  = m_ctrl[4] && (m_flag != 0);
    if (we) begin
      if (a <= 3'd1) begin m_pol[a] = wd[15]; m_thr[a] = sx14(wd[13:0]); end
      else if (a <= 3'd3) m_cnt[a-2] = int'(wd[7:0]);
      else if (a == 3'd4) m_ctrl = int'(wd[4:0]);
    end
    @(negedge clk);
    chk({tag, " flags"}, 32'(alm_flag), 32'(m_flag));
    chk({tag, " pin R10"}, 32'(alm_pin), 32'(m_pin));
    if (re) chk({tag, " rdata"}, 32'(reg_rdata), 32'(exp_rd));
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] wd, input string tag);
    step(0, '0, 1, 0, a, wd, tag);
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    step(0, '0, 0, 1, a, '0, tag);
  endtask
  task automatic smp(input int s, input string tag);
    step(1, 14'(s), 0, 0, 3'd0, '0, tag);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", 32'(alm_flag), 0);
    chk("R1 pin in reset", 32'(alm_pin), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 flags after reset", 32'(alm_flag), 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), "R1 register reset value");
      chk("R1 reg zero", 32'(reg_rdata), 0);
    end

    // R2 field masking and readback
    wr(3'd0, 16'hFFFF, "R2 write mag0");
    rd(3'd0, "R2 read mag0");
    chk("R2 mag bit14 reads zero", 32'(reg_rdata), 32'h0000BFFF);
    wr(3'd3, 16'hABCD, "R2 write cnt1");
    rd(3'd3, "R2 read cnt1");
    chk("R2 cnt upper bits zero", 32'(reg_rdata), 32'h000000CD);
    wr(3'd4, 16'hFFE0, "R2 write ctrl");
    rd(3'd4, "R2 read ctrl");
    chk("R2 ctrl upper bits zero", 32'(reg_rdata), 0);

    // R3 static, ch0 greater-than 100, ch1 less-than -5, pin enabled
    wr(3'd0, 16'h8000 | 16'd100, "R3 cfg mag0");
    wr(3'd1, {2'b00, 14'(-5)}, "R3 cfg mag1");
    wr(3'd4, 16'h0013, "R3 cfg ctrl");
    smp(100, "R3 equal no alarm");
    chk("R3 equal not greater", 32'(alm_flag), 0);
    smp(101, "R3 above alarm");
    chk("R3 ch0 greater fires", 32'(alm_flag), 1);
    chk("R10 pin follows flag", 32'(alm_pin), 1);
    rd(3'd5, "R8 status read");
    chk("R8 read shows old flags", 32'(reg_rdata), 1);
    chk("R8 cleared after read", 32'(alm_flag), 0);
    smp(-5, "R3 ch1 equal");
    chk("R3 ch1 equal no alarm", 32'(alm_flag), 0);
    smp(-6, "R3 ch1 below");
    chk("R6 ch1 alone fires", 32'(alm_flag), 2);

    // R11 no strobe
    rd(3'd5, "R8 clear");
    step(0, 14'(500), 0, 0, 3'd0, '0, "R11 no strobe");
    chk("R11 unstrobed sample ignored", 32'(alm_flag), 0);

    // R9 event colliding with clear
    smp(200, "R9 set");
    step(1, 14'(200), 0, 1, 3'd5, '0, "R9 collide");
    chk("R9 read shows old", 32'(reg_rdata), 1);
    chk("R9 event beats clear", 32'(alm_flag), 1);
    rd(3'd5, "R8 clear");

    // R4 dynamic ch0: N=3, threshold 10 greater-than
    wr(3'd0, 16'h8000 | 16'd10, "R4 mag");
    wr(3'd2, 16'd3, "R4 cnt");
    wr(3'd4, 16'h0015, "R4 ctrl dyn0");
    smp(0, "R4 seed");
    smp(10, "R4 d1"); smp(20, "R4 d2"); smp(30, "R4 d3");
    chk("R4 average equal no alarm", 32'(alm_flag), 0);
    smp(41, "R4 d1"); smp(52, "R4 d2");
    chk("R4 no alarm mid window", 32'(alm_flag), 0);
    smp(63, "R4 d3");
    chk("R4 average above fires", 32'(alm_flag), 1);
    rd(3'd5, "R8 clear");

    // R7 disable then re-enable: first sample only seeds
    wr(3'd4, 16'h0000, "R7 disable");
    smp(5000, "R7 disabled sample");
    chk("R7 disabled no flag", 32'(alm_flag), 0);
    wr(3'd2, 16'd0, "R5 cnt zero");
    wr(3'd4, 16'h0015, "R7 re-enable");
    smp(4000, "R7 seed only");
    chk("R7 first sample seeds", 32'(alm_flag), 0);
    smp(4011, "R5 single delta window");
    chk("R5 N=0 acts as 1", 32'(alm_flag), 1);

    // R10 pin gated off
    wr(3'd4, 16'h0005, "R10 pin off");
    smp(4030, "R10 event");
    chk("R10 pin gated", 32'(alm_pin), 0);
    rd(3'd5, "R8 clear");

    // random phase
    for (int it = 0; it < 4000; it++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3) begin
        int a;
        logic [15:0] w;
        a = int'($urandom_range(0, 4));
        if (a <= 1) w = {1'($urandom_range(0,1)), 1'b0, 14'(int'($urandom_range(0,400)) - 200)};
        else if (a <= 3) w = 16'($urandom_range(0, 4));
        else w = 16'($urandom_range(0, 31));
        step(1'($urandom_range(0,1)), 14'(int'($urandom_range(0,600)) - 300), 1, 0, 3'(a), w, "R6 random cfg");
      end else begin
        bit re;
        re = ($urandom_range(0, 7) == 0);
        step(1'($urandom_range(0,3) != 0), 14'(int'($urandom_range(0,600)) - 300), 0, re,
             re ? 3'd5 : 3'(int'($urandom_range(0,5))), '0, "R4 random");
      end
    end

    done = 1'b1;
    report();
  end
endmodule